// File: doc/BRIEF.md
# Transmit FIFO with Start Threshold

This block is a byte-wide transmit buffer. On one side a bus loader writes packet bytes, and on the other side a line transmitter drains them. A packet may start on the line before all of it has arrived. The block decides when that start happens by comparing the bytes already buffered for the packet with a level taken from a speed-dependent table. A store-and-forward setting makes the block hold every packet until its end marker is buffered.

A started packet cannot pause. If the transmitter strobes for a byte while the buffer is empty, the packet is lost. The block raises an underflow pulse and sets a sticky flag. It then throws away the rest of that packet as the loader delivers it, so the next packet starts clean. In automatic mode each underflow raises the threshold code by one step. An underflow at the top code turns on store-and-forward.

Top module: `tx_start_fifo`

## Requirements
- R1: A byte is accepted on each cycle where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` goes low only when the buffer holds DEPTH (2048) bytes.
- R2: With `fast_i`=0 and store-and-forward off, an idle block starts a packet once that many of its bytes are buffered: 72 for threshold code 0, 96 for 1, 128 for 2 and 160 for 3. `rd_active_o` rises one cycle after the write that reaches the level.
- R3: With `fast_i`=1, the start levels for codes 0, 1, 2 and 3 are 128, 256, 512 and 1024 bytes.
- R4: While `sf_o` is high, `rd_active_o` stays low until the packet's end marker (`wr_last_i`=1) has been written, whatever the byte count.
- R5: A packet shorter than the active level starts one cycle after its end marker is written.
- R6: While `rd_active_o` is high, `rd_data_o` and `rd_last_o` show the next byte in write order, and each `rd_strobe_i` consumes one byte. `rd_active_o` falls in the cycle after the strobe that takes the byte marked last.
- R7: A strobe while `rd_active_o` is high and no byte is buffered is an underflow. On the next cycle `urun_o` is high for exactly one cycle and `rd_active_o` is low.
- R8: After an underflow, the remaining bytes of the broken packet, up to and including its end marker, are discarded. The first byte presented afterwards is the first byte of the next packet.
- R9: With `auto_i`=1, each underflow raises `thr_code_o` by one. An underflow at code 3 sets `sf_o` instead. Both update in the same cycle that `urun_o` is high.
- R10: With `auto_i`=0, `thr_code_o` and `sf_o` take the values of `thr_code_i` and `sf_en_i` one cycle later, and underflows do not change them.
- R11: `urun_sticky_o` is set by an underflow and cleared by a one-cycle `urun_clr_i` pulse. Setting wins over clearing.
- R12: After reset, `wr_ready_o`=1, `rd_active_o`=0, `urun_o`=0, `urun_sticky_o`=0, `thr_code_o`=0 and `sf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Loader offers a byte |
| wr_ready_o | output | 1 | Buffer can accept a byte |
| wr_data_i | input | 8 | Byte from the loader |
| wr_last_i | input | 1 | Offered byte ends its packet |
| thr_code_i | input | 2 | Threshold code (manual mode) |
| fast_i | input | 1 | 1 selects the 100 Mb level table, 0 the 10 Mb table |
| sf_en_i | input | 1 | Store-and-forward request |
| auto_i | input | 1 | 1 lets underflows escalate the threshold |
| urun_clr_i | input | 1 | Write-one clear of the sticky underflow flag |
| rd_strobe_i | input | 1 | Transmitter takes the presented byte |
| rd_active_o | output | 1 | A packet is being sent |
| rd_data_o | output | 8 | Byte presented to the transmitter |
| rd_last_o | output | 1 | Presented byte ends its packet |
| urun_o | output | 1 | One-cycle underflow pulse |
| urun_sticky_o | output | 1 | Sticky underflow flag |
| thr_code_o | output | 2 | Threshold code in force |
| sf_o | output | 1 | Store-and-forward in force |

## Verification
The hardest state to reach is the switch to store-and-forward. It needs four underflows in a row in automatic mode, each at a higher level, and each broken packet must have its tail discarded before the next attempt. For each step the bench buffers exactly the current level's worth of bytes without an end marker. It then drains them all and sends one more strobe into the empty buffer. It also delivers the broken packet's tail and then a fresh packet, whose bytes must come out unmixed with the discarded ones.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int LVL_W = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DROP} tx_state_e;

  // start level in bytes for a speed and threshold code
  function automatic logic [LVL_W-1:0] start_level(input logic fast, input logic [1:0] code);
    if (fast) return LVL_W'(128) << code;
    case (code)
      2'd0:    return LVL_W'(72);
      2'd1:    return LVL_W'(96);
      2'd2:    return LVL_W'(128);
      default: return LVL_W'(160);
    endcase
  endfunction
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_data_o,
  output logic          head_last_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW:0]   mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= {last_i, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign {head_last_o, head_data_o} = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_last_i,
  input  logic             empty_i,
  input  logic             head_last_i,
  input  logic [CW-1:0]    count_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             sf_i,
  input  logic             strobe_i,
  output logic             pop_o,
  output logic             active_o,
  output logic             urun_o,
  output logic [CW-1:0]    eop_cnt_o
);
  tx_state_e     state_q, state_d;
  logic [CW-1:0] eop_q;
  logic          start_ok;

  // whole FIFO content belongs to the head packet until an end marker is in
  assign start_ok = (count_i != '0) &&
                    ((eop_q != '0) || (!sf_i && count_i >= CW'(level_i)));

  always_comb begin
    state_d = state_q;
    pop_o   = 1'b0;
    urun_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_SEND;
      ST_SEND: if (strobe_i) begin
        if (empty_i) begin
          urun_o  = 1'b1;
          state_d = ST_DROP;
        end else begin
          pop_o = 1'b1;
          if (head_last_i) state_d = ST_IDLE;
        end
      end
      ST_DROP: if (!empty_i) begin
        pop_o = 1'b1;
        if (head_last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      eop_q   <= '0;
    end else begin
      state_q <= state_d;
      eop_q   <= eop_q + CW'(push_i & push_last_i) - CW'(pop_o & head_last_i);
    end
  end

  assign active_o  = (state_q == ST_SEND);
  assign eop_cnt_o = eop_q;
endmodule

// File: rtl/tsf_esc.sv
module tsf_esc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_i,
  input  logic [1:0] code_i,
  input  logic       sf_en_i,
  input  logic       urun_i,
  input  logic       clr_i,
  output logic [1:0] code_o,
  output logic       sf_o,
  output logic       urun_o,
  output logic       sticky_o
);
  logic [1:0] code_q;
  logic       sf_q, urun_q, sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      sf_q     <= 1'b0;
      urun_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      urun_q   <= urun_i;
      sticky_q <= urun_i | (sticky_q & ~clr_i);
      if (!auto_i) begin
        code_q <= code_i;
        sf_q   <= sf_en_i;
      end else if (urun_i) begin
        if (&code_q) sf_q <= 1'b1;
        else         code_q <= code_q + 2'd1;
      end else begin
        sf_q <= sf_q | sf_en_i;
      end
    end
  end

  assign code_o   = code_q;
  assign sf_o     = sf_q;
  assign urun_o   = urun_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/tx_start_fifo.sv
module tx_start_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_last_i,
  input  logic [1:0]    thr_code_i,
  input  logic          fast_i,
  input  logic          sf_en_i,
  input  logic          auto_i,
  input  logic          urun_clr_i,
  input  logic          rd_strobe_i,
  output logic          rd_active_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_last_o,
  output logic          urun_o,
  output logic          urun_sticky_o,
  output logic [1:0]    thr_code_o,
  output logic          sf_o
);
  logic             push, pop, fifo_empty, fifo_full, urun_det;
  logic [CW-1:0]    fifo_count, eop_cnt;
  logic [LVL_W-1:0] level;

  assign push       = wr_valid_i & ~fifo_full;
  assign wr_ready_o = ~fifo_full;
  assign level      = start_level(fast_i, thr_code_o);

  tsf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(wr_data_i), .last_i(wr_last_i), .pop_i(pop),
    .head_data_o(rd_data_o), .head_last_o(rd_last_o),
    .count_o(fifo_count), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  tsf_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .push_i(push), .push_last_i(wr_last_i),
    .empty_i(fifo_empty), .head_last_i(rd_last_o), .count_i(fifo_count),
    .level_i(level), .sf_i(sf_o), .strobe_i(rd_strobe_i),
    .pop_o(pop), .active_o(rd_active_o), .urun_o(urun_det), .eop_cnt_o(eop_cnt)
  );

  tsf_esc u_esc (
    .clk_i, .rst_ni,
    .auto_i, .code_i(thr_code_i), .sf_en_i, .urun_i(urun_det), .clr_i(urun_clr_i),
    .code_o(thr_code_o), .sf_o, .urun_o, .sticky_o(urun_sticky_o)
  );
endmodule

// File: rtl/tx_start_fifo_chk.sv
module tx_start_fifo_chk #(
  parameter int DEPTH = 2048,
  parameter int CW    = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_ready_o,
  input logic          rd_active_o,
  input logic          rd_strobe_i,
  input logic          rd_last_o,
  input logic          urun_o,
  input logic          urun_sticky_o,
  input logic [1:0]    thr_code_o,
  input logic          sf_o,
  input logic          auto_i,
  input logic          empty_i,
  input logic [CW-1:0] count_i,
  input logic [CW-1:0] eop_cnt_i
);
  a_r1_ready_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |-> count_i == CW'(DEPTH));

  a_r4_sf_waits_for_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active_o) && $past(sf_o) |-> $past(eop_cnt_i) != '0);

  a_r6_stop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o && rd_strobe_i && !empty_i && rd_last_o |=> !rd_active_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_o |=> !urun_o);

  a_r7_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_o |-> $past(rd_active_o && rd_strobe_i && empty_i));

  a_r9_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_o && $past(auto_i) && $past(thr_code_o) != 2'd3 |->
      thr_code_o == 2'($past(thr_code_o) + 2'd1));

  a_r9_top_to_sf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_o && $past(auto_i) && $past(thr_code_o) == 2'd3 |-> sf_o);

  a_r11_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_o |-> urun_sticky_o);
endmodule

bind tx_start_fifo tx_start_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i, .rst_ni, .wr_ready_o, .rd_active_o, .rd_strobe_i, .rd_last_o,
  .urun_o, .urun_sticky_o, .thr_code_o, .sf_o, .auto_i,
  .empty_i(fifo_empty), .count_i(fifo_count), .eop_cnt_i(eop_cnt)
);

// File: tb/tx_start_fifo_bench.sv
module tx_start_fifo_bench;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 0, wr_last_i = 0, fast_i = 0, sf_en_i = 0, auto_i = 0;
  logic       urun_clr_i = 0, rd_strobe_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] thr_code_i = '0;
  logic       wr_ready_o, rd_active_o, rd_last_o, urun_o, urun_sticky_o, sf_o;
  logic [7:0] rd_data_o;
  logic [1:0] thr_code_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  tx_start_fifo #(.DEPTH(DEPTH)) u_tx_start_fifo (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic l);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = d; wr_last_i = l;
    @(posedge clk);
    #1 wr_valid_i = 1'b0; wr_last_i = 1'b0;
  endtask

  task automatic put_run(input logic [7:0] seed, input int n, input bit end_pkt);
    for (int i = 0; i < n; i++) put(seed + 8'(i), end_pkt && (i == n - 1));
  endtask

  task automatic take(input logic [7:0] exp_d, input logic exp_l, input string req);
    @(negedge clk);
    while (!rd_active_o) @(negedge clk);
    chk(rd_data_o == exp_d, req, rd_data_o, exp_d);
    chk(rd_last_o == exp_l, req, rd_last_o, exp_l);
    rd_strobe_i = 1'b1;
    @(posedge clk);
    #1 rd_strobe_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(wr_ready_o == 1, "R12 ready", wr_ready_o, 1);
    chk(rd_active_o == 0, "R12 active", rd_active_o, 0);
    chk(urun_o == 0, "R12 urun", urun_o, 0);
    chk(urun_sticky_o == 0, "R12 sticky", urun_sticky_o, 0);
    chk(thr_code_o == 0, "R12 code", thr_code_o, 0);
    chk(sf_o == 0, "R12 sf", sf_o, 0);
  endtask

  task automatic t_manual;
    auto_i = 0; thr_code_i = 2'd2; sf_en_i = 1;
    idle(2);
    chk(thr_code_o == 2, "R10 code follows", thr_code_o, 2);
    chk(sf_o == 1, "R10 sf follows", sf_o, 1);
    thr_code_i = 2'd0; sf_en_i = 0;
    idle(2);
    chk(thr_code_o == 0, "R10 code back", thr_code_o, 0);
    chk(sf_o == 0, "R10 sf back", sf_o, 0);
  endtask

  task automatic t_level(input logic fast, input logic [1:0] code, input int lvl,
                         input logic [7:0] seed, input string req);
    fast_i = fast; thr_code_i = code;
    idle(2);
    put_run(seed, lvl - 1, 0);
    idle(2);
    chk(rd_active_o == 0, req, rd_active_o, 0);
    put(seed + 8'(lvl - 1), 0);
    idle(2);
    chk(rd_active_o == 1, req, rd_active_o, 1);
    put(seed + 8'(lvl), 0);
    put(seed + 8'(lvl + 1), 1);
    for (int i = 0; i < lvl + 2; i++) take(seed + 8'(i), i == lvl + 1, "R6 order");
    idle(1);
    chk(rd_active_o == 0, "R6 ends after last", rd_active_o, 0);
  endtask

  task automatic t_short;
    fast_i = 1; thr_code_i = 2'd3;
    idle(2);
    put_run(8'h40, 4, 0);
    idle(2);
    chk(rd_active_o == 0, "R5 below level", rd_active_o, 0);
    put(8'h44, 1);
    idle(2);
    chk(rd_active_o == 1, "R5 starts on end marker", rd_active_o, 1);
    for (int i = 0; i < 5; i++) take(8'h40 + 8'(i), i == 4, "R5 data");
    idle(1);
  endtask

  task automatic t_underflow(input int lvl, input logic [7:0] seed,
                             input int exp_code, input int exp_sf);
    put_run(seed, lvl, 0);
    for (int i = 0; i < lvl; i++) take(seed + 8'(i), 0, "R6 pre-underflow data");
    @(negedge clk);
    chk(rd_active_o == 1, "R7 still sending", rd_active_o, 1);
    rd_strobe_i = 1'b1;
    @(posedge clk);
    #1 rd_strobe_i = 1'b0;
    idle(1);
    chk(urun_o == 1, "R7 pulse", urun_o, 1);
    chk(rd_active_o == 0, "R7 send stops", rd_active_o, 0);
    chk(urun_sticky_o == 1, "R11 sticky set", urun_sticky_o, 1);
    chk(thr_code_o == 2'(exp_code), "R9 code step", thr_code_o, exp_code);
    chk(sf_o == exp_sf, "R9 sf", sf_o, exp_sf);
    idle(1);
    chk(urun_o == 0, "R7 one cycle", urun_o, 0);
    put_run(8'hE0, 3, 1);
    put_run(8'h10, 2, 1);
    take(8'h10, 0, "R8 next packet first byte");
    take(8'h11, 1, "R8 next packet end");
    idle(1);
  endtask

  task automatic t_clear;
    @(negedge clk);
    urun_clr_i = 1'b1;
    @(posedge clk);
    #1 urun_clr_i = 1'b0;
    idle(1);
    chk(urun_sticky_o == 0, "R11 cleared", urun_sticky_o, 0);
  endtask

  task automatic t_sf;
    put_run(8'h20, 200, 0);
    idle(3);
    chk(rd_active_o == 0, "R4 holds above levels", rd_active_o, 0);
    put(8'h20 + 8'(200), 1);
    idle(2);
    chk(rd_active_o == 1, "R4 starts at end", rd_active_o, 1);
    for (int i = 0; i < 201; i++) take(8'h20 + 8'(i), i == 200, "R4 data");
    idle(1);
  endtask

  task automatic t_full;
    auto_i = 0; sf_en_i = 1; fast_i = 0; thr_code_i = 0;
    idle(2);
    put_run(8'h00, DEPTH - 1, 0);
    idle(1);
    chk(wr_ready_o == 1, "R1 ready below full", wr_ready_o, 1);
    put(8'(DEPTH - 1), 0);
    idle(1);
    chk(wr_ready_o == 0, "R1 not ready when full", wr_ready_o, 0);
    sf_en_i = 0;
    for (int i = 0; i < DEPTH; i++) take(8'(i), 0, "R1 stored data");
    put(8'h5A, 1);
    take(8'h5A, 1, "R1 final byte");
    idle(1);
    chk(wr_ready_o == 1, "R1 ready after drain", wr_ready_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_manual();
    t_level(0, 2'd0, 72,   8'h00, "R2 code0");
    t_level(0, 2'd1, 96,   8'h31, "R2 code1");
    t_level(0, 2'd2, 128,  8'h62, "R2 code2");
    t_level(0, 2'd3, 160,  8'h93, "R2 code3");
    t_level(1, 2'd0, 128,  8'h05, "R3 code0");
    t_level(1, 2'd1, 256,  8'h17, "R3 code1");
    t_level(1, 2'd2, 512,  8'h29, "R3 code2");
    t_level(1, 2'd3, 1024, 8'h3B, "R3 code3");
    t_short();
    fast_i = 0; thr_code_i = 2'd0; sf_en_i = 0;
    idle(2);
    auto_i = 1;
    t_underflow(72,  8'h70, 1, 0);
    t_underflow(96,  8'h71, 2, 0);
    t_clear();
    t_underflow(128, 8'h72, 3, 0);
    t_underflow(160, 8'h73, 3, 1);
    t_sf();
    t_full();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule